// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor core stops ordinary execution and switches into a private debug mode, and it steers the core's bus cycles while that mode is active. A halt can be requested either from an outside pin (passed through a small synchronizer) or from an internal debug event. The core is never stopped part-way through an instruction: a request is held until the core reports an instruction boundary. After that boundary the block asks an external engine to save the core state into the private space. It waits for that engine's done handshake before it settles in debug mode.

While debug mode is active, `dbg_mode_o` is high. It also appears as one extra, most significant address bit on the outgoing address, which selects the private memory space. Ordinary memory requests then go out on an alternate strobe/ready pair, so the normal bus stays idle. A request flagged as a user-memory transfer always uses the normal strobe/ready pair and the user address space, in either mode. A resume command returns the core to normal execution through a single restore cycle.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the block is in normal execution: `dbg_mode_o`, `save_req_o`, `restore_req_o` and `alt_as_o` are all low.
- R2: A break request (internal event, or synchronized pin) that arrives in normal execution without an instruction boundary is held pending. State saving begins on the edge where `insn_bound_i` is next high, even if the request has dropped by then.
- R3: A break request together with `insn_bound_i` in normal execution starts state saving at that same clock edge.
- R4: `brk_pin_i` passes through SYNC_STAGES flip-flops (default 2). With the default, a pin raised alongside a steady boundary strobe moves `dbg_mode_o` high only after the third rising edge.
- R5: `dbg_mode_o` is high while saving, in debug mode and while restoring. `save_req_o` stays high until `save_done_i` is seen, and debug mode is entered on that edge.
- R6: In debug mode, a request without the user flag drives `alt_as_o` high and `norm_as_o` low. It returns `alt_rdy_i` on `core_rdy_o` and sets address bit ADDR_W of `bus_addr_o` to 1, with the lower bits equal to `mem_addr_i`.
- R7: A request with `mem_user_i` high drives `norm_as_o` high and `alt_as_o` low, returns `bus_rdy_i` on `core_rdy_o`, and sets address bit ADDR_W to 0, whatever the mode.
- R8: Outside debug mode every request goes out on `norm_as_o` with address bit ADDR_W at 0, and the user flag changes nothing.
- R9: `resume_i` in debug mode gives exactly one cycle with `restore_req_o` high, after which the block is back in normal execution. `resume_i` in any other state has no effect.
- R10: Break requests are ignored while saving, in debug mode and while restoring. A break and a resume in the same debug-mode cycle resolve in favour of the resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_pin_i | input | 1 | External break request, asynchronous |
| brk_evt_i | input | 1 | Internal debug-event break request |
| insn_bound_i | input | 1 | Current instruction retires this cycle |
| resume_i | input | 1 | Leave debug mode |
| save_done_i | input | 1 | State save into the private space is complete |
| mem_req_i | input | 1 | Core memory cycle request |
| mem_user_i | input | 1 | Request is a user-memory transfer |
| mem_addr_i | input | ADDR_W | Core address |
| bus_rdy_i | input | 1 | Ready from the normal bus |
| alt_rdy_i | input | 1 | Ready from the alternate debug bus |
| dbg_mode_o | output | 1 | Debug mode active |
| save_req_o | output | 1 | Request to the save engine |
| restore_req_o | output | 1 | Restore cycle in progress |
| norm_as_o | output | 1 | Normal address strobe |
| alt_as_o | output | 1 | Alternate debug address strobe |
| core_rdy_o | output | 1 | Ready returned to the core from the selected pair |
| bus_addr_o | output | ADDR_W+1 | Outgoing address; top bit selects the private space |

## Verification
The properties assume that `save_done_i` only matters while `save_req_o` is high. They also assume that the ready inputs are sampled only in cycles where a request is present, and that the user flag is meaningful only together with `mem_req_i`. The stimulus raises `save_done_i` only in the saving state, except for deliberate cases that show it is ignored elsewhere. It changes the request, flag and ready inputs only at falling edges, so the combinational steering is always seen with stable inputs. The break pin is driven at a falling edge and held for several cycles, so the synchronizer latency can be counted exactly.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_WAIT_BND = 3'd1,
        ST_SAVE     = 3'd2,
        ST_DEBUG    = 3'd3,
        ST_RESTORE  = 3'd4
    } dbg_state_e;

    typedef struct packed {
        dbg_state_e state;
    } fsm_regs_t;

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_d;
            logic [STAGES-1:0] chain_q;

            always_comb begin
                chain_d[0] = async_i;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= chain_d;
                end
            end

            assign sync_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_req_i,
    input  logic insn_bound_i,
    input  logic resume_i,
    input  logic save_done_i,
    output logic dbg_mode_o,
    output logic save_req_o,
    output logic restore_req_o
);

    fsm_regs_t regs_d;
    fsm_regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_RUN: begin
                if (brk_req_i) begin
                    regs_d.state = insn_bound_i ? ST_SAVE : ST_WAIT_BND;
                end
            end
            ST_WAIT_BND: begin
                if (insn_bound_i) begin
                    regs_d.state = ST_SAVE;
                end
            end
            ST_SAVE: begin
                if (save_done_i) begin
                    regs_d.state = ST_DEBUG;
                end
            end
            ST_DEBUG: begin
                if (resume_i) begin
                    regs_d.state = ST_RESTORE;
                end
            end
            ST_RESTORE: begin
                regs_d.state = ST_RUN;
            end
            default: begin
                regs_d.state = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_RUN;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign save_req_o    = (regs_q.state == ST_SAVE);
    assign restore_req_o = (regs_q.state == ST_RESTORE);
    assign dbg_mode_o    = (regs_q.state == ST_SAVE)  ||
                           (regs_q.state == ST_DEBUG) ||
                           (regs_q.state == ST_RESTORE);

endmodule

// File: rtl/dbg_bus_steer.sv
module dbg_bus_steer #(
    parameter int ADDR_W = 32
) (
    input  logic              dbg_mode_i,
    input  logic              mem_req_i,
    input  logic              mem_user_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic              bus_rdy_i,
    input  logic              alt_rdy_i,
    output logic              norm_as_o,
    output logic              alt_as_o,
    output logic              core_rdy_o,
    output logic [ADDR_W:0]   bus_addr_o
);

    logic to_alt;

    always_comb begin
        to_alt     = dbg_mode_i && !mem_user_i;
        norm_as_o  = mem_req_i && !to_alt;
        alt_as_o   = mem_req_i && to_alt;
        core_rdy_o = mem_req_i && (to_alt ? alt_rdy_i : bus_rdy_i);
        bus_addr_o = {to_alt, mem_addr_i};
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_pin_i,
    input  logic              brk_evt_i,
    input  logic              insn_bound_i,
    input  logic              resume_i,
    input  logic              save_done_i,
    input  logic              mem_req_i,
    input  logic              mem_user_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic              bus_rdy_i,
    input  logic              alt_rdy_i,
    output logic              dbg_mode_o,
    output logic              save_req_o,
    output logic              restore_req_o,
    output logic              norm_as_o,
    output logic              alt_as_o,
    output logic              core_rdy_o,
    output logic [ADDR_W:0]   bus_addr_o
);

    logic pin_sync;
    logic brk_any;

    dbg_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (brk_pin_i),
        .sync_o  (pin_sync)
    );

    assign brk_any = pin_sync || brk_evt_i;

    dbg_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .brk_req_i     (brk_any),
        .insn_bound_i  (insn_bound_i),
        .resume_i      (resume_i),
        .save_done_i   (save_done_i),
        .dbg_mode_o    (dbg_mode_o),
        .save_req_o    (save_req_o),
        .restore_req_o (restore_req_o)
    );

    dbg_bus_steer #(
        .ADDR_W (ADDR_W)
    ) u_steer (
        .dbg_mode_i (dbg_mode_o),
        .mem_req_i  (mem_req_i),
        .mem_user_i (mem_user_i),
        .mem_addr_i (mem_addr_i),
        .bus_rdy_i  (bus_rdy_i),
        .alt_rdy_i  (alt_rdy_i),
        .norm_as_o  (norm_as_o),
        .alt_as_o   (alt_as_o),
        .core_rdy_o (core_rdy_o),
        .bus_addr_o (bus_addr_o)
    );

endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic resume_i,
    input logic save_done_i,
    input logic mem_req_i,
    input logic mem_user_i,
    input logic bus_rdy_i,
    input logic alt_rdy_i,
    input logic dbg_mode_o,
    input logic save_req_o,
    input logic restore_req_o,
    input logic norm_as_o,
    input logic alt_as_o,
    input logic core_rdy_o,
    input logic addr_msb_i
);

    p_alt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode_o |-> !alt_as_o && !addr_msb_i);

    p_user_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_i && mem_user_i |-> norm_as_o && !alt_as_o && !addr_msb_i);

    p_dbg_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_i && dbg_mode_o && !mem_user_i |-> alt_as_o && !norm_as_o && addr_msb_i);

    p_rdy_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_i && dbg_mode_o && !mem_user_i |-> core_rdy_o == alt_rdy_i);

    p_rdy_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_i && (!dbg_mode_o || mem_user_i) |-> core_rdy_o == bus_rdy_i);

    p_entry_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_mode_o) |-> save_req_o);

    p_save_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        save_req_o && !save_done_i |=> save_req_o);

    p_save_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        save_req_o && save_done_i |=> dbg_mode_o && !save_req_o && !restore_req_o);

    p_restore_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req_o |=> !restore_req_o && !dbg_mode_o);

    p_exit_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dbg_mode_o) |-> $past(restore_req_o));

    p_debug_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode_o && !save_req_o && !restore_req_o && !resume_i |=> dbg_mode_o && !save_req_o);

endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .resume_i      (resume_i),
    .save_done_i   (save_done_i),
    .mem_req_i     (mem_req_i),
    .mem_user_i    (mem_user_i),
    .bus_rdy_i     (bus_rdy_i),
    .alt_rdy_i     (alt_rdy_i),
    .dbg_mode_o    (dbg_mode_o),
    .save_req_o    (save_req_o),
    .restore_req_o (restore_req_o),
    .norm_as_o     (norm_as_o),
    .alt_as_o      (alt_as_o),
    .core_rdy_o    (core_rdy_o),
    .addr_msb_i    (bus_addr_o[ADDR_W])
);

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;

    localparam int ADDR_W = 32;
    localparam int NVEC   = 15;

    // {evt, bound, resume, save_done, exp_dbg, exp_save, exp_restore}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0000_000,  // R1 idle in run
        7'b1000_000,  // R2 break, no boundary -> pending
        7'b0000_000,  // R2 request dropped, still pending
        7'b0100_110,  // R2 boundary -> save
        7'b0010_110,  // R9 resume ignored while saving
        7'b0001_100,  // R5 save done -> debug
        7'b1000_100,  // R10 break ignored in debug
        7'b1010_101,  // R10 break+resume -> restore
        7'b1000_000,  // R9 restore lasts one cycle, break ignored
        7'b1100_110,  // R3 break with boundary -> save at once
        7'b0001_100,  // R5 debug
        7'b0010_101,  // R9 resume -> restore
        7'b0000_000,  // R9 back in run
        7'b0010_000,  // R9 resume in run ignored
        7'b0101_000   // R2 boundary and save_done without break ignored
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              brk_pin_i = 1'b0;
    logic              brk_evt_i = 1'b0;
    logic              insn_bound_i = 1'b0;
    logic              resume_i = 1'b0;
    logic              save_done_i = 1'b0;
    logic              mem_req_i = 1'b0;
    logic              mem_user_i = 1'b0;
    logic [ADDR_W-1:0] mem_addr_i = '0;
    logic              bus_rdy_i = 1'b0;
    logic              alt_rdy_i = 1'b0;
    logic              dbg_mode_o;
    logic              save_req_o;
    logic              restore_req_o;
    logic              norm_as_o;
    logic              alt_as_o;
    logic              core_rdy_o;
    logic [ADDR_W:0]   bus_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dbg_entry_ctrl #(
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .brk_pin_i     (brk_pin_i),
        .brk_evt_i     (brk_evt_i),
        .insn_bound_i  (insn_bound_i),
        .resume_i      (resume_i),
        .save_done_i   (save_done_i),
        .mem_req_i     (mem_req_i),
        .mem_user_i    (mem_user_i),
        .mem_addr_i    (mem_addr_i),
        .bus_rdy_i     (bus_rdy_i),
        .alt_rdy_i     (alt_rdy_i),
        .dbg_mode_o    (dbg_mode_o),
        .save_req_o    (save_req_o),
        .restore_req_o (restore_req_o),
        .norm_as_o     (norm_as_o),
        .alt_as_o      (alt_as_o),
        .core_rdy_o    (core_rdy_o),
        .bus_addr_o    (bus_addr_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_ctl();
        brk_evt_i    = 1'b0;
        brk_pin_i    = 1'b0;
        insn_bound_i = 1'b0;
        resume_i     = 1'b0;
        save_done_i  = 1'b0;
    endtask

    // status = {dbg, save, restore}
    function automatic logic [2:0] status();
        return {dbg_mode_o, save_req_o, restore_req_o};
    endfunction

    // bus = {norm_as, alt_as, core_rdy, addr_msb}
    function automatic logic [3:0] busv();
        return {norm_as_o, alt_as_o, core_rdy_o, bus_addr_o[ADDR_W]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a request present
        mem_req_i = 1'b1;
        bus_rdy_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 status in reset", status(), 3'b000);
        check("R1 alt strobe in reset", alt_as_o, 1'b0);
        rst_n = 1'b1;
        mem_req_i = 1'b0;
        step();
        check("R1 status after reset", status(), 3'b000);

        // table walk of the mode sequencing
        for (int i = 0; i < NVEC; i++) begin
            brk_evt_i    = VEC[i][6];
            insn_bound_i = VEC[i][5];
            resume_i     = VEC[i][4];
            save_done_i  = VEC[i][3];
            step();
            check($sformatf("R2/R3/R5/R9/R10 vector %0d", i), status(), VEC[i][2:0]);
        end
        clear_ctl();

        // R8: run mode steering, user flag has no effect
        mem_req_i  = 1'b1;
        mem_addr_i = 32'hA5A5_1234;
        bus_rdy_i  = 1'b1;
        alt_rdy_i  = 1'b0;
        mem_user_i = 1'b0;
        #1;
        check("R8 run ordinary", busv(), 4'b1010);
        check("R8 run address", bus_addr_o, {1'b0, 32'hA5A5_1234});
        mem_user_i = 1'b1;
        #1;
        check("R8 run user flag", busv(), 4'b1010);
        mem_req_i  = 1'b0;
        mem_user_i = 1'b0;

        // enter debug mode
        brk_evt_i    = 1'b1;
        insn_bound_i = 1'b1;
        step();
        clear_ctl();
        save_done_i = 1'b1;
        step();
        clear_ctl();
        check("R5 in debug", status(), 3'b100);

        // R6: debug steering onto alternate pair
        mem_req_i = 1'b1;
        #1;
        check("R6 debug ordinary, alt not ready", busv(), 4'b0101);
        check("R6 debug address", bus_addr_o, {1'b1, 32'hA5A5_1234});
        alt_rdy_i = 1'b1;
        bus_rdy_i = 1'b0;
        #1;
        check("R6 debug ready from alt", busv(), 4'b0111);

        // R7: user transfer in debug uses normal pair
        mem_user_i = 1'b1;
        #1;
        check("R7 debug user, bus not ready", busv(), 4'b1000);
        bus_rdy_i = 1'b1;
        #1;
        check("R7 debug user ready", busv(), 4'b1010);
        mem_req_i  = 1'b0;
        mem_user_i = 1'b0;

        // R10: break with resume in debug, then back to run
        brk_evt_i = 1'b1;
        resume_i  = 1'b1;
        step();
        clear_ctl();
        check("R10 resume wins", status(), 3'b101);
        step();
        check("R9 back to run", status(), 3'b000);

        // R4: pin synchronizer latency with steady boundary strobe
        brk_pin_i    = 1'b1;
        insn_bound_i = 1'b1;
        step();
        check("R4 first edge", dbg_mode_o, 1'b0);
        step();
        check("R4 second edge", dbg_mode_o, 1'b0);
        step();
        check("R4 third edge", status(), 3'b110);
        clear_ctl();

        // R1: reset in the middle of saving
        mem_req_i = 1'b1;
        rst_n     = 1'b0;
        #1;
        check("R1 mid-save reset status", status(), 3'b000);
        check("R1 mid-save reset strobes", busv(), 4'b1010);
        step();
        rst_n     = 1'b1;
        mem_req_i = 1'b0;
        step();
        check("R1 run after reset", status(), 3'b000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule